// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block observes the two pulse trains that meet at a phase-frequency detector: the divided reference and the divided feedback. It uses a fast sampling clock to measure the phase error of every comparison cycle. The error is the number of sampling-clock cycles between the edge that arrives first and the edge that arrives second. From these measurements it produces a single active-high lock flag that a control loop or a monitor can read directly.

The detector has hysteresis. While hunting, it declares lock only after a run of consecutive comparisons whose error is below a set threshold. The run length is 3 or 5 and is chosen by a precision-select input. Once locked, it stays locked until one comparison shows an error above a larger clear threshold, or until the second edge fails to arrive. All timing limits are parameters counted in sampling-clock cycles. Both pulse inputs pass through synchronizers of the same depth, so the measured error is not skewed.

The meter state machine has three states. `MS_IDLE` waits for a leading edge. `MS_REF_LEAD` means the reference edge came first and the feedback edge is awaited. `MS_FB_LEAD` means the feedback edge came first and the reference edge is awaited. Its transitions are: start (IDLE to a LEAD state), coincident (IDLE stays, error 0), close (LEAD to IDLE with the counted error), slip (the leading input fires again, LEAD to IDLE, overrun result) and expire (count reaches the timeout, LEAD to IDLE, overrun result). The lock state machine has two states, `LS_HUNT` and `LS_LOCKED`. Its transitions are: acquire (HUNT to LOCKED when the run completes), restart (HUNT stays, run cleared by a non-qualifying result) and drop (LOCKED to HUNT on an error above the clear limit or an overrun).

Top module: `pll_lock_detect`

## Requirements
- R1: The phase error of a comparison is the count of sampling-clock cycles from the first-arriving rising edge to the second-arriving rising edge. It is measured the same way whichever input leads, and edges in the same cycle give an error of 0.
- R2: With `prec_sel` = 0, `lock_o` goes high after exactly 3 consecutive comparisons with error below `SET_CNT`, and not after 2.
- R3: With `prec_sel` = 1, `lock_o` goes high after exactly 5 consecutive qualifying comparisons, and not after 4.
- R4: Once high, `lock_o` stays high for comparisons with error up to and including `CLR_CNT`. It falls after a single comparison with error greater than `CLR_CNT`.
- R5: While unlocked, a comparison with error equal to or above `SET_CNT` clears the consecutive count to zero.
- R6: If the second edge has not arrived `TIMEOUT_CNT` cycles after the first, or the leading input fires again first, the comparison counts as exceeding `CLR_CNT`.
- R7: Reset (active-low `rst_n`) clears `lock_o` and the consecutive count.
- R8: `lock_o` is active high: 1 means locked, 0 means unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Divided reference pulse; its rising edge marks a comparison |
| fb_pulse | input | 1 | Divided feedback pulse; its rising edge marks a comparison |
| prec_sel | input | 1 | 0 requires a run of 3 qualifying comparisons, 1 requires 5 |
| lock_o | output | 1 | Lock flag, high when locked |

## Verification
The bench builds the block with `SET_CNT` = 4, `CLR_CNT` = 8 and `TIMEOUT_CNT` = 20, and keeps the 2-stage synchronizers. These small limits let directed pulse pairs with delays of 0 to 9 cycles land on both sides of each threshold: 3 versus 4 for the set limit, and 8 versus 9 for the clear limit. The short timeout lets a missing feedback pulse expire within a few dozen cycles. Run lengths of 3 and 5 are reached by toggling `prec_sel` between scenarios, with a reset in between.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

    // Phase meter states
    typedef enum logic [1:0] {
        MS_IDLE     = 2'd0,
        MS_REF_LEAD = 2'd1,
        MS_FB_LEAD  = 2'd2
    } meas_state_e;

    // Lock qualifier states
    typedef enum logic {
        LS_HUNT   = 1'b0,
        LS_LOCKED = 1'b1
    } lock_state_e;

    // Channel indices for the synchronized edge vector
    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/pll_ld_edge_sync.sv
module pll_ld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pulse_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pulse_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pll_ld_phase_meter.sv
module pll_ld_phase_meter
    import pll_ld_pkg::*;
#(
    parameter int TIMEOUT_CNT = 64,
    localparam int CNT_W      = $clog2(TIMEOUT_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output logic             res_valid,
    output logic             res_overrun,
    output logic [CNT_W-1:0] res_err
);
    meas_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             lead_rise, lag_rise;

    // Edge roles depend on which input opened the comparison
    always_comb begin
        lead_rise = 1'b0;
        lag_rise  = 1'b0;
        unique case (state_q)
            MS_REF_LEAD: begin lead_rise = ref_rise; lag_rise = fb_rise;  end
            MS_FB_LEAD:  begin lead_rise = fb_rise;  lag_rise = ref_rise; end
            default:     begin lead_rise = 1'b0;     lag_rise = 1'b0;     end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next state and result outputs
    always_comb begin
        state_n     = state_q;
        cnt_n       = cnt_q;
        res_valid   = 1'b0;
        res_overrun = 1'b0;
        res_err     = cnt_q;
        unique case (state_q)
            MS_IDLE: begin
                if (ref_rise && fb_rise) begin          // coincident
                    res_valid = 1'b1;
                    res_err   = '0;
                end else if (ref_rise) begin            // start, reference first
                    state_n = MS_REF_LEAD;
                    cnt_n   = CNT_W'(1);
                end else if (fb_rise) begin             // start, feedback first
                    state_n = MS_FB_LEAD;
                    cnt_n   = CNT_W'(1);
                end
            end
            MS_REF_LEAD, MS_FB_LEAD: begin
                if (lag_rise) begin                     // close
                    res_valid = 1'b1;
                    res_err   = cnt_q;
                    state_n   = MS_IDLE;
                    cnt_n     = '0;
                end else if (lead_rise) begin           // slip
                    res_valid   = 1'b1;
                    res_overrun = 1'b1;
                    state_n     = MS_IDLE;
                    cnt_n       = '0;
                end else if (cnt_q == CNT_W'(TIMEOUT_CNT)) begin // expire
                    res_valid   = 1'b1;
                    res_overrun = 1'b1;
                    state_n     = MS_IDLE;
                    cnt_n       = '0;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_n = MS_IDLE;
                cnt_n   = '0;
            end
        endcase
    end
endmodule

// File: rtl/pll_ld_lock_fsm.sv
module pll_ld_lock_fsm
    import pll_ld_pkg::*;
#(
    parameter int SET_CNT     = 3,
    parameter int CLR_CNT     = 5,
    parameter int LOW_RUN     = 3,
    parameter int HIGH_RUN    = 5,
    parameter int CNT_W       = 7,
    localparam int MAX_RUN    = (HIGH_RUN > LOW_RUN) ? HIGH_RUN : LOW_RUN,
    localparam int RUN_W      = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prec_sel,
    input  logic             res_valid,
    input  logic             res_overrun,
    input  logic [CNT_W-1:0] res_err,
    output logic             lock_o
);
    lock_state_e      state_q, state_n;
    logic [RUN_W-1:0] run_q, run_n;
    logic [RUN_W-1:0] need;
    logic             qualify, breach;

    assign need    = prec_sel ? RUN_W'(HIGH_RUN) : RUN_W'(LOW_RUN);
    assign qualify = !res_overrun && (res_err < CNT_W'(SET_CNT));
    assign breach  = res_overrun  || (res_err > CNT_W'(CLR_CNT));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_HUNT;
            run_q   <= '0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        unique case (state_q)
            LS_HUNT: begin
                if (res_valid) begin
                    if (qualify) begin
                        if ((run_q + RUN_W'(1)) >= need) begin   // acquire
                            state_n = LS_LOCKED;
                            run_n   = '0;
                        end else begin
                            run_n = run_q + RUN_W'(1);
                        end
                    end else begin                               // restart
                        run_n = '0;
                    end
                end
            end
            LS_LOCKED: begin
                if (res_valid && breach) begin                   // drop
                    state_n = LS_HUNT;
                    run_n   = '0;
                end
            end
            default: begin
                state_n = LS_HUNT;
                run_n   = '0;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_o <= 1'b0;
        else        lock_o <= (state_n == LS_LOCKED);
    end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_ld_pkg::*;
#(
    parameter int SET_CNT     = 3,
    parameter int CLR_CNT     = 5,
    parameter int TIMEOUT_CNT = 64,
    parameter int LOW_RUN     = 3,
    parameter int HIGH_RUN    = 5,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(TIMEOUT_CNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic prec_sel,
    output logic lock_o
);
    logic [N_CH-1:0]  pulse_vec;
    logic [N_CH-1:0]  rise_vec;
    logic             res_valid;
    logic             res_overrun;
    logic [CNT_W-1:0] res_err;

    assign pulse_vec[CH_REF] = ref_pulse;
    assign pulse_vec[CH_FB]  = fb_pulse;

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
            pll_ld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .pulse_in (pulse_vec[ch]),
                .rise_o   (rise_vec[ch])
            );
        end
    endgenerate

    pll_ld_phase_meter #(.TIMEOUT_CNT(TIMEOUT_CNT)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_rise    (rise_vec[CH_REF]),
        .fb_rise     (rise_vec[CH_FB]),
        .res_valid   (res_valid),
        .res_overrun (res_overrun),
        .res_err     (res_err)
    );

    pll_ld_lock_fsm #(
        .SET_CNT  (SET_CNT),
        .CLR_CNT  (CLR_CNT),
        .LOW_RUN  (LOW_RUN),
        .HIGH_RUN (HIGH_RUN),
        .CNT_W    (CNT_W)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .prec_sel    (prec_sel),
        .res_valid   (res_valid),
        .res_overrun (res_overrun),
        .res_err     (res_err),
        .lock_o      (lock_o)
    );
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
    parameter int SET_CNT = 3,
    parameter int CLR_CNT = 5,
    parameter int CNT_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_o,
    input logic             res_valid,
    input logic             res_overrun,
    input logic [CNT_W-1:0] res_err
);
    // R7
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !lock_o);

    // R2 R3
    rise_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(res_valid) && !$past(res_overrun));

    // R4
    hold_in_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o && res_valid && !res_overrun && (res_err <= CNT_W'(CLR_CNT)) |=> lock_o);

    // R4
    drop_on_breach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o && res_valid && !res_overrun && (res_err > CNT_W'(CLR_CNT)) |=> !lock_o);

    // R6
    drop_on_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o && res_valid && res_overrun |=> !lock_o);

    // R5
    no_lock_on_poor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o && res_valid && (res_overrun || res_err >= CNT_W'(SET_CNT)) |=> !lock_o);

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(lock_o));
endmodule

bind pll_lock_detect pll_lock_detect_chk #(
    .SET_CNT (SET_CNT),
    .CLR_CNT (CLR_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_o      (lock_o),
    .res_valid   (res_valid),
    .res_overrun (res_overrun),
    .res_err     (res_err)
);

// File: tb/pll_lock_detect_bench.sv
module pll_lock_detect_bench;
    localparam int SET_T = 4;
    localparam int CLR_T = 8;
    localparam int TMO_T = 20;
    localparam int SETTLE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0;
    logic fb_pulse = 1'b0;
    logic prec_sel = 1'b0;
    logic lock_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pll_lock_detect #(
        .SET_CNT     (SET_T),
        .CLR_CNT     (CLR_T),
        .TIMEOUT_CNT (TMO_T),
        .LOW_RUN     (3),
        .HIGH_RUN    (5),
        .SYNC_STAGES (2)
    ) u_pll_lock_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .prec_sel  (prec_sel),
        .lock_o    (lock_o)
    );

    task automatic check(input logic exp, input string tag);
        total++;
        if (lock_o !== exp) begin
            bad++;
            $display("FAIL %s lock_o actual=%b expected=%b", tag, lock_o, exp);
        end
    endtask

    task automatic do_reset(input logic psel);
        @(negedge clk);
        rst_n = 1'b0;
        prec_sel = psel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One comparison: the leading pulse, then the lagging one d cycles later
    task automatic compare(input int d, input bit fb_first);
        @(negedge clk);
        if (fb_first) fb_pulse = 1'b1; else ref_pulse = 1'b1;
        if (d == 0) begin ref_pulse = 1'b1; fb_pulse = 1'b1; end
        @(negedge clk);
        ref_pulse = 1'b0;
        fb_pulse  = 1'b0;
        if (d > 0) begin
            repeat (d - 1) @(negedge clk);
            if (fb_first) ref_pulse = 1'b1; else fb_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0;
            fb_pulse  = 1'b0;
        end
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic lone_ref();
        @(negedge clk);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        repeat (TMO_T + SETTLE) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        check(1'b0, "R7 reset state");
        check(1'b0, "R8 unlocked reads 0");
    endtask

    task automatic t_run_of_three();
        do_reset(1'b0);
        compare(1, 1'b0);
        compare(3, 1'b0);
        check(1'b0, "R2 two good not enough");
        compare(2, 1'b0);
        check(1'b1, "R2 third good sets lock");
    endtask

    task automatic t_hysteresis();
        compare(6, 1'b0);
        check(1'b1, "R4 error 6 keeps lock");
        compare(CLR_T, 1'b1);
        check(1'b1, "R4 error at clear limit keeps lock");
        compare(CLR_T + 1, 1'b0);
        check(1'b0, "R4 error above clear limit drops");
    endtask

    task automatic t_run_of_five();
        do_reset(1'b1);
        for (int k = 0; k < 4; k++) compare(k % 4, k[0]);
        check(1'b0, "R3 four good not enough");
        compare(3, 1'b1);
        check(1'b1, "R3 fifth good sets lock");
    endtask

    task automatic t_run_restart();
        do_reset(1'b0);
        compare(1, 1'b0);
        compare(SET_T - 1, 1'b0);
        compare(SET_T, 1'b0);
        compare(0, 1'b0);
        compare(2, 1'b0);
        check(1'b0, "R5 error at set limit restarts run");
        compare(1, 1'b1);
        check(1'b1, "R5 run completes after restart");
    endtask

    task automatic t_lead_order();
        do_reset(1'b0);
        compare(SET_T - 1, 1'b1);
        compare(SET_T - 1, 1'b1);
        compare(0, 1'b1);
        check(1'b1, "R1 feedback-first and coincident edges qualify");
        compare(CLR_T + 1, 1'b1);
        check(1'b0, "R1 feedback-first large error measured");
    endtask

    task automatic t_timeout();
        do_reset(1'b0);
        compare(0, 1'b0);
        compare(0, 1'b0);
        compare(0, 1'b0);
        check(1'b1, "R6 lock before missing edge");
        lone_ref();
        check(1'b0, "R6 missing feedback drops lock");
    endtask

    task automatic t_reset_mid_run();
        do_reset(1'b0);
        compare(1, 1'b0);
        compare(1, 1'b0);
        do_reset(1'b0);
        compare(1, 1'b0);
        check(1'b0, "R7 reset cleared run count");
        compare(1, 1'b0);
        check(1'b0, "R7 two after reset still hunting");
        compare(1, 1'b0);
        check(1'b1, "R7 three after reset lock");
    endtask

    initial begin
        t_reset_state();
        t_run_of_three();
        t_hysteresis();
        t_run_of_five();
        t_run_restart();
        t_lead_order();
        t_timeout();
        t_reset_mid_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule